// File: doc/BRIEF.md
# Synchronous Burst Read Address Sequencer

This block is the clocked read front end of a parallel memory with a 19-bit word address and a 32-bit data path. When the host selects the device and strobes the address latch, the block captures a start address. It then counts a programmable number of active burst-clock edges before it presents the first word. After that it moves through the address space one word per step for as long as the host asks it to advance. The storage array sits outside the block. The block drives the array's read address and registers the word that comes back onto its own data bus, together with an output-valid flag.

The burst clock is not used as a clock. The block samples it on a single rising-edge system clock and detects the configured transition, rising or falling, so all state is synchronous to that system clock. A 5-bit configuration word selects the edge polarity, the initial latency and the output rate. The latency and the output rate are frozen when a burst starts. A ready input can hold the sequencer in place while the advance request stays asserted. The address counter wraps from the top of the space to zero, so a burst can run on indefinitely.

The array address output always points at the word that will be presented at the next step. The array may therefore be combinational, or it may be a memory that is read asynchronously.

Top module: `burst_rd_seq`

## Requirements
- R1: After a synchronous reset `dq_oe` is 0, `mem_addr` is 0 and `dq_out` is 0.
- R2: In idle, with `cen_n` low, an active burst-clock edge seen while `lat_n` is low captures `addr_in` into `mem_addr` at that system-clock edge. The capture edge itself does not count toward the latency.
- R3: In idle, with `cen_n` low, a rising transition of `lat_n` also captures `addr_in`. This happens without any burst-clock edge, so capture takes place on whichever of the two events comes first.
- R4: `cfg[0]` selects the active burst-clock transition: 0 means low-to-high and 1 means high-to-low. A transition is recognised at the first system-clock edge at which the new `bclk` level is sampled.
- R5: `cfg[3:1]` is the latency field N. The first word is presented on the (N+2)-th active edge after capture: `dq_oe` rises, `dq_out` holds the word at the captured address, and `mem_addr` moves to that address plus one.
- R6: During a burst, an active edge with `adv_n` low and `rdy` high presents the word at `mem_addr` and increments `mem_addr`. With `adv_n` high the output and the address hold.
- R7: An active edge with `rdy` low presents no new word and does not increment `mem_addr`, even if `adv_n` is low.
- R8: With `cfg[4]`=1 (half rate), a phase bit is cleared at the first word and toggles on every later active edge. A step is allowed only on edges where the phase bit is 1, which gives at most one word per two active edges. `cfg[4]` and `cfg[3:1]` are sampled at capture.
- R9: The address counter wraps from 0x7FFFF to 0x00000 and the burst continues.
- R10: `cen_n` high at a system-clock edge ends any burst: `dq_oe` is 0 after that edge and a new capture is needed.
- R11: Without an active burst-clock edge, `dq_out` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bclk | input | 1 | Burst clock level, sampled on `clk` |
| cen_n | input | 1 | Chip enable, active low |
| lat_n | input | 1 | Address latch strobe, active low |
| adv_n | input | 1 | Burst advance request, active low |
| rdy | input | 1 | Ready; low blocks a step |
| cfg | input | 5 | {half_rate, latency[2:0], falling_edge} |
| addr_in | input | 19 | Burst start address |
| mem_rdata | input | 32 | Word read from the array at `mem_addr` |
| mem_addr | output | 19 | Address of the next word to present |
| dq_out | output | 32 | Registered output word |
| dq_oe | output | 1 | Output valid / drive enable |

## Verification
Every result is registered once after the system-clock edge that samples its cause. A capture, a step, a stall and a `cen_n` abort are each visible one nanosecond after the `clk` edge at which the relevant `bclk`, `lat_n` or `cen_n` level is first sampled. The first word follows (N+2) recognised active edges after the capture edge. The bench drives all inputs on the falling edge of `clk` and updates its reference model at the rising edge with the same input values. It compares `dq_oe`, `mem_addr` and, while valid, `dq_out` shortly after every rising edge, so no result is sampled before or after its cycle.

// File: rtl/burst_rd_seq_pkg.sv
package burst_rd_seq_pkg;
  localparam int LAT_W    = 3;
  localparam int LAT_BASE = 2;
  localparam int CNT_W    = LAT_W + 1;
  localparam int CFG_W    = LAT_W + 2;

  typedef struct packed {
    logic             half;
    logic [LAT_W-1:0] lat;
    logic             fall;
  } cfg_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LAT   = 2'd1,
    ST_BURST = 2'd2
  } seq_st_t;
endpackage

// File: rtl/brs_edge.sv
module brs_edge (
  input  logic clk,
  input  logic rst,
  input  logic bclk,
  input  logic lat_n,
  input  logic fall,
  output logic kedge,
  output logic lat_rise
);
  logic bclk_d;
  logic lat_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_d <= 1'b0;
      lat_d  <= 1'b1;
    end else begin
      bclk_d <= bclk;
      lat_d  <= lat_n;
    end
  end

  always_comb begin
    if (fall) kedge = bclk_d & ~bclk;
    else      kedge = ~bclk_d & bclk;
    lat_rise = lat_n & ~lat_d;
  end
endmodule

// File: rtl/brs_ctrl.sv
module brs_ctrl
  import burst_rd_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             kedge,
  input  logic             lat_rise,
  input  logic             cen_n,
  input  logic             lat_n,
  input  logic             adv_n,
  input  logic             rdy,
  input  logic [LAT_W-1:0] cfg_lat,
  input  logic             cfg_half,
  output logic             load,
  output logic             first,
  output logic             step,
  output seq_st_t          st
);
  logic [CNT_W-1:0] cnt;
  logic             ph;
  logic             half_r;

  always_comb begin
    load  = (st == ST_IDLE) && !cen_n && ((kedge && !lat_n) || lat_rise);
    first = (st == ST_LAT) && !cen_n && kedge && (cnt == CNT_W'(1));
    step  = (st == ST_BURST) && !cen_n && kedge && rdy && !adv_n
            && (!half_r || ph);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      ph     <= 1'b0;
      half_r <= 1'b0;
    end else if (cen_n) begin
      st <= ST_IDLE;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (load) begin
            st     <= ST_LAT;
            cnt    <= CNT_W'(cfg_lat) + CNT_W'(LAT_BASE);
            half_r <= cfg_half;
          end
        end
        ST_LAT: begin
          if (first) begin
            st <= ST_BURST;
            ph <= 1'b0;
          end else if (kedge) begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        ST_BURST: begin
          if (kedge) ph <= ~ph;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R5: the latency counter never reaches zero while waiting
  assert_lat_cnt_live_R5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_LAT) |-> (cnt != '0));
endmodule

// File: rtl/brs_data.sv
module brs_data #(
  parameter int AW = 19,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          first,
  input  logic          step,
  input  logic          stop,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] ptr,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe
);
  localparam logic [AW-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr    <= '0;
      dq_out <= '0;
      dq_oe  <= 1'b0;
    end else begin
      if (load) ptr <= addr_in;
      else if (first || step) begin
        ptr    <= ptr + AW'(1);
        dq_out <= mem_rdata;
      end
      if (stop)       dq_oe <= 1'b0;
      else if (first) dq_oe <= 1'b1;
    end
  end

  // R9: stepping from the top address lands on zero
  assert_wrap_R9: assert property (@(posedge clk) disable iff (rst)
    (step && ptr == TOP) |=> (ptr == '0));
endmodule

// File: rtl/burst_rd_seq.sv
module burst_rd_seq
  import burst_rd_seq_pkg::*;
#(
  parameter int AW = 19,
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bclk,
  input  logic             cen_n,
  input  logic             lat_n,
  input  logic             adv_n,
  input  logic             rdy,
  input  logic [CFG_W-1:0] cfg,
  input  logic [AW-1:0]    addr_in,
  input  logic [DW-1:0]    mem_rdata,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    dq_out,
  output logic             dq_oe
);
  cfg_t    c;
  logic    kedge, lat_rise, load, first, step;
  seq_st_t st;

  assign c = cfg_t'(cfg);

  brs_edge u_edge (
    .clk(clk), .rst(rst), .bclk(bclk), .lat_n(lat_n), .fall(c.fall),
    .kedge(kedge), .lat_rise(lat_rise)
  );

  brs_ctrl u_ctrl (
    .clk(clk), .rst(rst), .kedge(kedge), .lat_rise(lat_rise),
    .cen_n(cen_n), .lat_n(lat_n), .adv_n(adv_n), .rdy(rdy),
    .cfg_lat(c.lat), .cfg_half(c.half),
    .load(load), .first(first), .step(step), .st(st)
  );

  brs_data #(.AW(AW), .DW(DW)) u_data (
    .clk(clk), .rst(rst), .load(load), .first(first), .step(step),
    .stop(cen_n), .addr_in(addr_in), .mem_rdata(mem_rdata),
    .ptr(mem_addr), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  // R2: a capture loads the start address
  assert_capture_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> (mem_addr == $past(addr_in)));
  // R7: ready low freezes address and data during a burst
  assert_stall_R7: assert property (@(posedge clk) disable iff (rst)
    (st == ST_BURST && !rdy && !cen_n) |=> ($stable(mem_addr) && $stable(dq_out)));
  // R10: deselect drops the output
  assert_deselect_R10: assert property (@(posedge clk) disable iff (rst)
    cen_n |=> !dq_oe);
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> !dq_oe);
  // R11: no burst-clock edge, no new data
  assert_no_edge_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !kedge |=> $stable(dq_out));
endmodule

// File: tb/test_burst_rd_seq.sv
`timescale 1ns/1ps
module test_burst_rd_seq;
  localparam int AW = 19;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst, bclk, cen_n, lat_n, adv_n, rdy;
  logic [4:0] cfg;
  logic [AW-1:0] addr_in, mem_addr;
  logic [DW-1:0] mem_rdata, dq_out;
  logic dq_oe;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  function automatic logic [DW-1:0] word(input logic [AW-1:0] a);
    return {a[12:0] ^ 13'h15A3, a};
  endfunction

  assign mem_rdata = word(mem_addr);

  burst_rd_seq #(.AW(AW), .DW(DW)) i_burst_rd_seq (
    .clk(clk), .rst(rst), .bclk(bclk), .cen_n(cen_n), .lat_n(lat_n),
    .adv_n(adv_n), .rdy(rdy), .cfg(cfg), .addr_in(addr_in),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  // reference model: 0 idle, 1 latency, 2 burst
  int            m_st;
  logic [AW-1:0] m_ptr;
  logic [DW-1:0] m_dq;
  logic          m_oe, m_ph, m_half, m_bp, m_lp;
  int            m_cnt;

  task automatic model(input logic b, ce, le, av, rd,
                       input logic [AW-1:0] a, input logic [4:0] c);
    logic e;
    logic lr;
    e  = c[0] ? (m_bp & ~b) : (~m_bp & b);
    lr = le & ~m_lp;
    m_bp = b;
    m_lp = le;
    if (ce) begin
      m_st = 0;
      m_oe = 1'b0;
    end else if (m_st == 0) begin
      if ((e && !le) || lr) begin
        m_ptr = a; m_cnt = int'(c[3:1]) + 2; m_half = c[4]; m_st = 1;
      end
    end else if (m_st == 1) begin
      if (e) begin
        if (m_cnt == 1) begin
          m_dq = word(m_ptr); m_ptr = m_ptr + 1'b1; m_oe = 1'b1;
          m_ph = 1'b0; m_st = 2;
        end else m_cnt = m_cnt - 1;
      end
    end else if (e) begin
      if ((!m_half || m_ph) && rd && !av) begin
        m_dq = word(m_ptr); m_ptr = m_ptr + 1'b1;
      end
      m_ph = ~m_ph;
    end
  endtask

  task automatic tick(input logic b, ce, le, av, rd,
                      input logic [AW-1:0] a, input logic [4:0] c,
                      input string tag);
    @(negedge clk);
    bclk = b; cen_n = ce; lat_n = le; adv_n = av; rdy = rd;
    addr_in = a; cfg = c;
    @(posedge clk);
    model(b, ce, le, av, rd, a, c);
    #1;
    n_chk++;
    if (dq_oe !== m_oe || mem_addr !== m_ptr || (m_oe && dq_out !== m_dq)) begin
      n_bad++;
      $display("FAIL %s: oe=%0b addr=%05h dq=%08h expected oe=%0b addr=%05h dq=%08h",
               tag, dq_oe, mem_addr, dq_out, m_oe, m_ptr, m_dq);
    end
  endtask

  // one active edge: inactive level, then active level
  task automatic act(input logic ce, le, av, rd, input logic [AW-1:0] a,
                     input logic [4:0] c, input string tag);
    tick(c[0], ce, le, av, rd, a, c, tag);
    tick(~c[0], ce, le, av, rd, a, c, tag);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [4:0] c;
    void'($urandom(32'd4242));
    rst = 1'b1; bclk = 1'b0; cen_n = 1'b1; lat_n = 1'b1; adv_n = 1'b1;
    rdy = 1'b1; cfg = '0; addr_in = '0;
    m_st = 0; m_ptr = '0; m_dq = '0; m_oe = 1'b0; m_ph = 1'b0;
    m_half = 1'b0; m_bp = 1'b0; m_lp = 1'b1; m_cnt = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    n_chk++;
    if (dq_oe !== 1'b0 || mem_addr !== '0 || dq_out !== '0) begin
      n_bad++;
      $display("FAIL R1: oe=%0b addr=%05h dq=%08h expected 0/0/0", dq_oe, mem_addr, dq_out);
    end

    // R2 + R5 + R6 + R7: rising edge, latency 2, full rate
    c = 5'b0_000_0;
    act(1'b0, 1'b0, 1'b1, 1'b1, 19'h00100, c, "R2");
    repeat (2) act(1'b0, 1'b1, 1'b1, 1'b1, 19'h0, c, "R5");
    repeat (3) act(1'b0, 1'b1, 1'b0, 1'b1, 19'h0, c, "R6");
    repeat (2) act(1'b0, 1'b1, 1'b1, 1'b1, 19'h0, c, "R6 hold");
    repeat (2) act(1'b0, 1'b1, 1'b0, 1'b0, 19'h0, c, "R7");
    act(1'b0, 1'b1, 1'b0, 1'b1, 19'h0, c, "R7 resume");
    // R10: deselect
    tick(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 19'h0, c, "R10");
    repeat (3) act(1'b0, 1'b1, 1'b0, 1'b1, 19'h0, c, "R10 idle");

    // R3: capture on latch strobe release, no clock edge; latency 5
    c = 5'b0_011_0;
    tick(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 19'h2ABCD, c, "R3");
    tick(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 19'h2ABCD, c, "R3");
    repeat (5) act(1'b0, 1'b1, 1'b0, 1'b1, 19'h0, c, "R5");
    tick(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 19'h0, c, "R10");

    // R4 + R9: falling edge, latency 9, across the top of the space
    c = 5'b0_111_1;
    tick(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 19'h0, c, "R4");
    act(1'b0, 1'b0, 1'b1, 1'b1, 19'h7FFFE, c, "R4");
    repeat (9) act(1'b0, 1'b1, 1'b0, 1'b1, 19'h0, c, "R5");
    repeat (4) act(1'b0, 1'b1, 1'b0, 1'b1, 19'h0, c, "R9");
    // R11: burst clock static
    repeat (10) tick(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 19'h0, c, "R11");
    tick(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 19'h0, c, "R10");

    // R8: half rate, latency 3
    c = 5'b1_001_0;
    tick(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 19'h0, c, "R8");
    act(1'b0, 1'b0, 1'b1, 1'b1, 19'h01234, c, "R8");
    repeat (3) act(1'b0, 1'b1, 1'b1, 1'b1, 19'h0, c, "R8");
    repeat (8) act(1'b0, 1'b1, 1'b0, 1'b1, 19'h0, c, "R8");
    act(1'b0, 1'b1, 1'b0, 1'b0, 19'h0, c, "R8");
    repeat (4) act(1'b0, 1'b1, 1'b0, 1'b1, 19'h0, c, "R8");
    tick(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 19'h0, c, "R10");

    // mixed random traffic
    c = 5'($urandom);
    for (int i = 0; i < 6000; i++) begin
      if (i % 300 == 0) c = 5'($urandom);
      tick(1'($urandom), ($urandom % 80) == 0, ($urandom % 10) != 0,
           ($urandom % 4) == 0, ($urandom % 8) != 0, 19'($urandom), c,
           "R6 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule